// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block sits in front of a small local memory made of 32-bit words and services atomic read-modify-write requests. A requester presents one request on a valid/ready channel. The request carries an operation code, an operand size, a word address, two operands and a tag. The block performs the whole read-modify-write as one indivisible step. It then returns one completion that carries the tag, a status code and, on success, the memory contents as they were before the operation.

Three operations are provided: fetch-and-add, unconditional swap and compare-and-swap. The operand width is 32, 64 or 128 bits. A multi-word operand occupies consecutive words, and the word at the request address holds the least significant 32 bits. Two kinds of request are turned away without touching memory: requests the block cannot service, and requests whose address is unusable. Each of these gets its own status code.

The block works on one request at a time. A request that has been accepted owns the memory until the requester takes its completion. Increments that arrive back to back, such as shared queue indices, therefore always build on each other.

Top module: `atomc_completer`

## Requirements
- R1: Fetch-and-add stores (old + operand A) modulo 2^width and returns the old value.
- R2: Swap stores operand A and returns the old value.
- R3: Compare-and-swap stores operand B only when the old value equals operand A. It returns the old value whether or not the comparison matched.
- R4: A 64-bit operand spans words addr and addr+1; a 128-bit operand spans words addr..addr+3; the lowest word holds bits 31:0. The 128-bit size is accepted only for compare-and-swap.
- R5: Encodings. Operation code: 00 add, 01 swap, 10 compare-and-swap, 11 reserved. Size: 00 32-bit, 01 64-bit, 10 128-bit, 11 reserved. Status: 00 success, 01 unsupported request, 10 completer abort.
- R6: These requests complete with unsupported request and leave memory unchanged: a reserved operation code, a reserved size, or the 128-bit size on add or swap.
- R7: A supported request completes with completer abort and leaves memory unchanged if its address is misaligned or its word address is at or beyond DEPTH. Misaligned means an odd address for 64-bit, or an address that is not a multiple of 4 for 128-bit.
- R8: While atomic_en is low at acceptance, every request completes with unsupported request and memory stays unchanged. This takes precedence over every other check.
- R9: Every completion echoes the request tag. Its data is zero whenever the status is not success.
- R10: req_ready is low from the acceptance edge until the edge on which the completion is taken, and it is high again after that edge.
- R11: While cpl_valid is high and cpl_ready is low, the completion tag, status and data hold steady.
- R12: cpl_valid rises on the second rising clock edge after the acceptance edge.
- R13: After reset, req_ready is high, cpl_valid is low and every memory word reads as zero.
- R14: Back-to-back 64-bit increments to one location accumulate exactly, with the carry passing from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| atomic_en | input | 1 | Atomic completion support enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_op | input | 2 | Operation code |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | 128 | Addend, swap value or compare value |
| req_opb | input | 128 | Swap value for compare-and-swap |
| req_tag | input | TAG_W | Request tag |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion ready |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_status | output | 2 | Completion status |
| cpl_data | output | 128 | Value before the operation, zero on error |

## Verification
The checker assumes that the requester holds atomic_en, the operation code and the size steady for the cycle of the acceptance edge. It also assumes that the requester never raises cpl_ready before a completion exists. The bench sets all request fields and atomic_en together on a falling edge, and it keeps them until it observes acceptance. It raises cpl_ready only after it has seen cpl_valid high. It sometimes withholds cpl_ready for a few cycles, so that the hold and busy properties are exercised while staying inside these assumptions.

// File: rtl/atomc_pkg.sv
package atomc_pkg;
   localparam int LANE_W = 32;
   localparam int LANES  = 4;
   localparam int BLK_W  = LANE_W * LANES;

   typedef enum logic [1:0] {
      OP_FADD = 2'b00,
      OP_SWAP = 2'b01,
      OP_CAS  = 2'b10,
      OP_RSVD = 2'b11
   } atom_op_e;

   typedef enum logic [1:0] {
      SZ_W32  = 2'b00,
      SZ_W64  = 2'b01,
      SZ_W128 = 2'b10,
      SZ_RSVD = 2'b11
   } atom_size_e;

   typedef enum logic [1:0] {
      ST_OK  = 2'b00,
      ST_UR  = 2'b01,
      ST_CA  = 2'b10,
      ST_RSV = 2'b11
   } cpl_stat_e;

   typedef enum logic [1:0] {
      FSM_IDLE = 2'b00,
      FSM_EXEC = 2'b01,
      FSM_RESP = 2'b10
   } fsm_e;
endpackage

// File: rtl/atomc_decode.sv
module atomc_decode
   import atomc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              en,
   input  atom_op_e          op,
   input  atom_size_e        size,
   input  logic [ADDR_W-1:0] addr,
   output cpl_stat_e         status,
   output logic [LANES-1:0]  lane_en
);
   logic op_known;
   logic size_fits;
   logic misaligned;
   logic out_of_range;

   always_comb begin
      op_known  = (op != OP_RSVD);
      unique case (size)
         SZ_W32, SZ_W64: size_fits = 1'b1;
         SZ_W128:        size_fits = (op == OP_CAS);
         default:        size_fits = 1'b0;
      endcase
   end

   always_comb begin
      unique case (size)
         SZ_W64:  misaligned = addr[0];
         SZ_W128: misaligned = |addr[1:0];
         default: misaligned = 1'b0;
      endcase
   end

   assign out_of_range = ({1'b0, addr} >= (ADDR_W+1)'(DEPTH));

   always_comb begin
      if (!en || !op_known || !size_fits) status = ST_UR;
      else if (misaligned || out_of_range) status = ST_CA;
      else                                 status = ST_OK;
   end

   always_comb begin
      unique case (size)
         SZ_W32:  lane_en = LANES'(4'b0001) << addr[1:0];
         SZ_W64:  lane_en = LANES'(4'b0011) << addr[1:0];
         default: lane_en = {LANES{1'b1}};
      endcase
   end
endmodule

// File: rtl/atomc_alu.sv
module atomc_alu
   import atomc_pkg::*;
(
   input  atom_op_e          op,
   input  atom_size_e        size,
   input  logic [BLK_W-1:0]  old_raw,
   input  logic [BLK_W-1:0]  opa,
   input  logic [BLK_W-1:0]  opb,
   output logic [BLK_W-1:0]  old_val,
   output logic [BLK_W-1:0]  new_val,
   output logic              commit
);
   logic [BLK_W-1:0] width_mask;
   logic [BLK_W-1:0] a_m;
   logic [BLK_W-1:0] b_m;
   logic [BLK_W-1:0] sum_m;
   logic             match;

   always_comb begin
      unique case (size)
         SZ_W32:  width_mask = {{(BLK_W-32){1'b0}}, {32{1'b1}}};
         SZ_W64:  width_mask = {{(BLK_W-64){1'b0}}, {64{1'b1}}};
         default: width_mask = {BLK_W{1'b1}};
      endcase
   end

   assign old_val = old_raw & width_mask;
   assign a_m     = opa & width_mask;
   assign b_m     = opb & width_mask;
   assign sum_m   = (old_val + a_m) & width_mask;
   assign match   = (old_val == a_m);

   always_comb begin
      unique case (op)
         OP_FADD: begin new_val = sum_m;   commit = 1'b1;  end
         OP_SWAP: begin new_val = a_m;     commit = 1'b1;  end
         OP_CAS:  begin new_val = b_m;     commit = match; end
         default: begin new_val = old_val; commit = 1'b0;  end
      endcase
   end
endmodule

// File: rtl/atomc_store.sv
module atomc_store
   import atomc_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter bit MEM_RESET = 1'b1,
   localparam int BLKS     = DEPTH / LANES,
   localparam int BIW      = $clog2(BLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BIW-1:0]   blk_idx,
   output logic [BLK_W-1:0] rd_blk,
   input  logic             we,
   input  logic [LANES-1:0] lane_en,
   input  logic [BLK_W-1:0] wr_blk
);
   logic [DEPTH*LANE_W-1:0] flat;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam int B = w / LANES;
      localparam int L = w % LANES;
      logic [LANE_W-1:0] q;
      logic              hit;

      assign hit = we && (blk_idx == BIW'(B)) && lane_en[L];

      if (MEM_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_blk[L*LANE_W +: LANE_W];
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) q <= wr_blk[L*LANE_W +: LANE_W];
         end
      end

      assign flat[w*LANE_W +: LANE_W] = q;
   end

   assign rd_blk = flat[blk_idx*BLK_W +: BLK_W];
endmodule

// File: rtl/atomc_completer.sv
module atomc_completer
   import atomc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DEPTH     = 16,
   parameter int TAG_W     = 8,
   parameter bit MEM_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              atomic_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [127:0]      req_opa,
   input  logic [127:0]      req_opb,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic [1:0]        cpl_status,
   output logic [127:0]      cpl_data
);
   localparam int BLKS = DEPTH / LANES;
   localparam int BIW  = $clog2(BLKS);

   if (DEPTH < 8)                 $error("DEPTH must be at least 8");
   if ((DEPTH & (DEPTH-1)) != 0)  $error("DEPTH must be a power of two");
   if (DEPTH > (1 << ADDR_W))     $error("DEPTH exceeds the address space");
   if (TAG_W < 1)                 $error("TAG_W must be positive");
   if (BLK_W != 128)              $error("block width must be 128 bits");

   fsm_e              state;
   atom_op_e          op_q;
   atom_size_e        size_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BLK_W-1:0]  opa_q;
   logic [BLK_W-1:0]  opb_q;
   logic [TAG_W-1:0]  tag_q;
   logic              en_q;

   cpl_stat_e         dec_status;
   logic [LANES-1:0]  lane_en;
   logic [BLK_W-1:0]  rd_blk;
   logic [BLK_W-1:0]  old_raw;
   logic [BLK_W-1:0]  old_val;
   logic [BLK_W-1:0]  new_val;
   logic [BLK_W-1:0]  wr_blk;
   logic              commit;
   logic              mem_we;

   cpl_stat_e         cpl_status_q;
   logic [BLK_W-1:0]  cpl_data_q;
   logic [TAG_W-1:0]  cpl_tag_q;

   atomc_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_decode (
      .en      (en_q),
      .op      (op_q),
      .size    (size_q),
      .addr    (addr_q),
      .status  (dec_status),
      .lane_en (lane_en)
   );

   atomc_store #(.DEPTH(DEPTH), .MEM_RESET(MEM_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk_idx (addr_q[BIW+1:2]),
      .rd_blk  (rd_blk),
      .we      (mem_we),
      .lane_en (lane_en),
      .wr_blk  (wr_blk)
   );

   assign old_raw = rd_blk >> (LANE_W * addr_q[1:0]);

   atomc_alu u_alu (
      .op      (op_q),
      .size    (size_q),
      .old_raw (old_raw),
      .opa     (opa_q),
      .opb     (opb_q),
      .old_val (old_val),
      .new_val (new_val),
      .commit  (commit)
   );

   assign wr_blk = new_val << (LANE_W * addr_q[1:0]);
   assign mem_we = (state == FSM_EXEC) && (dec_status == ST_OK) && commit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= FSM_IDLE;
         op_q         <= OP_FADD;
         size_q       <= SZ_W32;
         addr_q       <= '0;
         opa_q        <= '0;
         opb_q        <= '0;
         tag_q        <= '0;
         en_q         <= 1'b0;
         cpl_status_q <= ST_OK;
         cpl_data_q   <= '0;
         cpl_tag_q    <= '0;
      end else begin
         unique case (state)
            FSM_IDLE: begin
               if (req_valid) begin
                  op_q   <= atom_op_e'(req_op);
                  size_q <= atom_size_e'(req_size);
                  addr_q <= req_addr;
                  opa_q  <= req_opa;
                  opb_q  <= req_opb;
                  tag_q  <= req_tag;
                  en_q   <= atomic_en;
                  state  <= FSM_EXEC;
               end
            end
            FSM_EXEC: begin
               cpl_status_q <= dec_status;
               cpl_data_q   <= (dec_status == ST_OK) ? old_val : '0;
               cpl_tag_q    <= tag_q;
               state        <= FSM_RESP;
            end
            FSM_RESP: begin
               if (cpl_ready) state <= FSM_IDLE;
            end
            default: state <= FSM_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == FSM_IDLE);
   assign cpl_valid  = (state == FSM_RESP);
   assign cpl_tag    = cpl_tag_q;
   assign cpl_status = cpl_status_q;
   assign cpl_data   = cpl_data_q;
endmodule

// File: rtl/atomc_completer_chk.sv
module atomc_completer_chk #(
   parameter int TAG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             atomic_en,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_op,
   input logic [1:0]       req_size,
   input logic             cpl_valid,
   input logic             cpl_ready,
   input logic [TAG_W-1:0] cpl_tag,
   input logic [1:0]       cpl_status,
   input logic [127:0]     cpl_data
);
   logic       en_cap;
   logic [1:0] op_cap;
   logic [1:0] size_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_cap   <= 1'b0;
         op_cap   <= 2'b00;
         size_cap <= 2'b00;
      end else if (req_valid && req_ready) begin
         en_cap   <= atomic_en;
         op_cap   <= req_op;
         size_cap <= req_size;
      end
   end

   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_busy_while_cpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> !req_ready);

   assert_cpl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag)
                                     && $stable(cpl_status) && $stable(cpl_data)));

   assert_err_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_status != 2'b00) |-> (cpl_data == 128'd0));

   assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (cpl_status != 2'b11));

   assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> ##1 $rose(cpl_valid));

   assert_disabled_ur_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpl_valid) && !en_cap) |-> (cpl_status == 2'b01));

   assert_reserved_ur_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpl_valid) && (op_cap == 2'b11 || size_cap == 2'b11)) |-> (cpl_status == 2'b01));
endmodule

bind atomc_completer atomc_completer_chk #(.TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .atomic_en  (atomic_en),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_op     (req_op),
   .req_size   (req_size),
   .cpl_valid  (cpl_valid),
   .cpl_ready  (cpl_ready),
   .cpl_tag    (cpl_tag),
   .cpl_status (cpl_status),
   .cpl_data   (cpl_data)
);

// File: tb/atomc_completer_tb.sv
`timescale 1ns/1ps
module atomc_completer_tb;
   localparam int ADDR_W = 5;
   localparam int DEPTH  = 16;
   localparam int TAG_W  = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              atomic_en = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [1:0]        req_op = '0;
   logic [1:0]        req_size = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [127:0]      req_opa = '0;
   logic [127:0]      req_opb = '0;
   logic [TAG_W-1:0]  req_tag = '0;
   logic              cpl_valid;
   logic              cpl_ready = 1'b0;
   logic [TAG_W-1:0]  cpl_tag;
   logic [1:0]        cpl_status;
   logic [127:0]      cpl_data;

   int          n_vec = 0;
   int          n_bad = 0;
   int          cycles = 0;
   logic [31:0] model [DEPTH];
   logic [31:0] rng = 32'h1234_5678;

   always #10 clk = ~clk;

   atomc_completer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .atomic_en(atomic_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_size(req_size), .req_addr(req_addr), .req_opa(req_opa),
      .req_opb(req_opb), .req_tag(req_tag), .cpl_valid(cpl_valid),
      .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
      .cpl_data(cpl_data)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic rnd(output logic [31:0] v);
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      v = rng;
   endtask

   task automatic rnd128(output logic [127:0] v);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
         rnd(w);
         v[i*32 +: 32] = w;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Encodings per R5: op 0 add, 1 swap, 2 cas, 3 reserved;
   // size 0/1/2 = 32/64/128, 3 reserved; status 0 ok, 1 UR, 2 CA.
   task automatic run_op(input logic [1:0] op, input logic [1:0] sz,
                         input logic [ADDR_W-1:0] addr, input logic [127:0] a_in,
                         input logic [127:0] b, input bit en, input bit want_match,
                         input int hold, input string force_req);
      int           n;
      logic [1:0]   exp_st;
      logic [127:0] mask, old, a, nv, snap_d;
      logic [1:0]   snap_s;
      logic [TAG_W-1:0] tag, snap_t;
      bit           wr;
      string        rq;
      n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      mask = (sz == 2'd0) ? 128'hFFFF_FFFF :
             (sz == 2'd1) ? 128'hFFFF_FFFF_FFFF_FFFF : {128{1'b1}};
      if (!en) exp_st = 2'd1;
      else if (op == 2'd3 || sz == 2'd3 || (sz == 2'd2 && op != 2'd2)) exp_st = 2'd1;
      else if ((sz == 2'd1 && addr[0]) || (sz == 2'd2 && addr[1:0] != 2'd0)
               || int'(addr) >= DEPTH) exp_st = 2'd2;
      else exp_st = 2'd0;
      old = '0;
      if (exp_st == 2'd0)
         for (int i = 0; i < n; i++) old[i*32 +: 32] = model[int'(addr) + i];
      a = (want_match && exp_st == 2'd0) ? old : a_in;
      wr = 1'b0;
      nv = old;
      if (exp_st == 2'd0) begin
         case (op)
            2'd0: begin nv = (old + (a & mask)) & mask; wr = 1'b1; end
            2'd1: begin nv = a & mask; wr = 1'b1; end
            default: begin
               if (old == (a & mask)) begin nv = b & mask; wr = 1'b1; end
            end
         endcase
      end
      if (wr)
         for (int i = 0; i < n; i++) model[int'(addr) + i] = nv[i*32 +: 32];
      tag = TAG_W'(n_vec);
      if (force_req != "") rq = force_req;
      else if (!en) rq = "R8";
      else if (exp_st == 2'd1) rq = "R6";
      else if (exp_st == 2'd2) rq = "R7";
      else if (sz == 2'd2) rq = "R4";
      else if (op == 2'd0) rq = "R1";
      else if (op == 2'd1) rq = "R2";
      else rq = "R3";

      @(negedge clk);
      req_op = op; req_size = sz; req_addr = addr; req_opa = a; req_opb = b;
      req_tag = tag; atomic_en = en; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(!cpl_valid, "R12", "cpl_valid one edge after accept", 128'(cpl_valid), 128'd0);
      check(!req_ready, "R10", "req_ready while busy", 128'(req_ready), 128'd0);
      @(negedge clk);
      check(cpl_valid, "R12", "cpl_valid two edges after accept", 128'(cpl_valid), 128'd1);
      snap_d = cpl_data; snap_s = cpl_status; snap_t = cpl_tag;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check(cpl_valid && cpl_data == snap_d && cpl_status == snap_s && cpl_tag == snap_t,
               "R11", "completion held", cpl_data, snap_d);
         check(!req_ready, "R10", "req_ready while completion pending", 128'(req_ready), 128'd0);
      end
      check(cpl_status == exp_st, rq, "status (R5 encoding)", 128'(cpl_status), 128'(exp_st));
      check(cpl_data == ((exp_st == 2'd0) ? old : 128'd0),
            (exp_st == 2'd0) ? rq : "R9", "data", cpl_data, (exp_st == 2'd0) ? old : 128'd0);
      check(cpl_tag == tag, "R9", "tag echo", 128'(cpl_tag), 128'(tag));
      cpl_ready = 1'b1;
      @(negedge clk);
      cpl_ready = 1'b0;
      check(req_ready && !cpl_valid, "R10", "ready after completion taken",
            128'(req_ready), 128'd1);
   endtask

   initial begin
      logic [127:0] a, b;
      logic [31:0]  r;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R13", "req_ready after reset", 128'(req_ready), 128'd1);
      check(!cpl_valid, "R13", "cpl_valid after reset", 128'(cpl_valid), 128'd0);
      // R13: memory reads as zero (CAS with mismatching compare returns old)
      for (int blk = 0; blk < DEPTH; blk += 4)
         run_op(2'd2, 2'd2, ADDR_W'(blk), {128{1'b1}}, 128'd0, 1'b1, 1'b0, 0, "R13");

      // Near-exhaustive sweep: op x size x every address, enable high
      for (int op = 0; op < 4; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int ad = 0; ad < (1 << ADDR_W); ad++) begin
               rnd128(a); rnd128(b); rnd(r);
               run_op(2'(op), 2'(sz), ADDR_W'(ad), a, b, 1'b1, r[0],
                      (ad % 5 == 0) ? 2 : 0, "");
            end

      // R8: enable low, valid requests still refused
      for (int op = 0; op < 3; op++)
         for (int ad = 0; ad < DEPTH; ad += 3) begin
            rnd128(a); rnd128(b);
            run_op(2'(op), 2'd0, ADDR_W'(ad), a, b, 1'b0, 1'b1, 0, "R8");
         end

      // R14: 64-bit increments back to back across the word carry
      run_op(2'd1, 2'd1, ADDR_W'(6), 128'h0000_0000_FFFF_FFF0, 128'd0, 1'b1, 1'b0, 0, "R14");
      for (int k = 0; k < 40; k++)
         run_op(2'd0, 2'd1, ADDR_W'(6), 128'd1, 128'd0, 1'b1, 1'b0, 0, "R14");
      run_op(2'd0, 2'd1, ADDR_W'(6), 128'd0, 128'd0, 1'b1, 1'b0, 0, "R14");
      check(model[6] == 32'h0000_0018 && model[7] == 32'd1, "R14", "model carry",
            {model[7], model[6]}, 128'h1_0000_0018);

      // Final readback of every word confirms refused requests wrote nothing
      for (int ad = 0; ad < DEPTH; ad++)
         run_op(2'd0, 2'd0, ADDR_W'(ad), 128'd0, 128'd0, 1'b1, 1'b0, 0, "R7");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule